// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a synchronous TFT panel: a horizontal sync pulse, a vertical sync pulse, a data-enable strobe and the column and row of the pixel currently on the wire. Software, or a neighbouring control block, gives each axis four numbers: the sync width, the start interval before valid data, the count of active pixels or lines, and the end interval after them. The block forms each axis period as start plus active plus end. It keeps that period and the sync width internally as value minus one.

A single-cycle write offers a complete new timing set. The set is checked, held as pending, and put into use only when the current frame finishes, so a frame in progress is never torn. All counting steps on a pixel clock enable. The same enable, with a chosen polarity, is brought out as the panel pixel clock. The pixel data bus passes through with an optional inversion. Each of the five panel-facing signals has its own polarity bit.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset both counters are zero and the default timing from the parameters is active, with no pending set.
- R2: The column counter runs from 0 to start+active+end-1 and advances once per cycle with `pix_en_i` high. The horizontal sync is asserted while the column is below the horizontal sync width.
- R3: The row counter advances only in a cycle where `pix_en_i` is high and the column is at its last value, and wraps after start+active+end rows. The vertical sync is asserted while the row is below the vertical sync width.
- R4: `x_o` is column-minus-start while the column lies in [start, start+active), and 0 otherwise. `y_o` follows the same rule for rows. Data-enable is asserted exactly when both axes are inside their active windows.
- R5: With `pix_en_i` low, no counter or output timing state changes.
- R6: Polarity bits: bit 0 = 1 makes hsync active high, bit 1 does the same for vsync, bit 2 = 1 makes data-enable active high, bit 3 = 1 inverts every bit of `pix_data_o` relative to `pix_data_i`, and bit 4 = 1 makes `pix_clk_o` the inverse of `pix_en_i`. A 0 in bits 0 to 2 gives an active-low signal.
- R7: A write whose horizontal or vertical sync width is zero is discarded, and any earlier pending set is kept.
- R8: A pending set becomes active on the clock edge that ends the last column of the last row with `pix_en_i` high. Both counters restart from zero on that edge. At no other time does the active timing change.
- R9: A second accepted write before the frame boundary replaces the earlier pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | Pixel clock enable |
| cfg_wr_i | input | 1 | Offers the timing set on the cfg inputs |
| cfg_h_sync_i | input | 6 | Horizontal sync width, pixels |
| cfg_h_start_i | input | 10 | Pixels from line start to first active pixel |
| cfg_h_active_i | input | 10 | Active pixels per line |
| cfg_h_tail_i | input | 10 | Pixels after the last active pixel |
| cfg_v_sync_i | input | 6 | Vertical sync width, lines |
| cfg_v_start_i | input | 10 | Lines from frame start to first active line |
| cfg_v_active_i | input | 10 | Active lines per frame |
| cfg_v_tail_i | input | 10 | Lines after the last active line |
| cfg_pol_i | input | 5 | Polarity selects (see R6) |
| pix_data_i | input | 8 | Pixel data from the fetch side |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_data_o | output | 8 | Pixel data to the panel |
| pix_clk_o | output | 1 | Pixel clock to the panel |
| x_o | output | 10 | Active column offset |
| y_o | output | 10 | Active row offset |

## Verification
The main raster is first run with the default timing and an enable that is always high. This shows the period and window edges without stalls. It is then run with an enable that drops every third cycle, which separates counting of clock cycles from counting of enabled cycles. Two further timing sets with different window sizes and inverted polarities are applied in the middle of a frame. These distinguish an immediate update from one taken at the boundary, and an axis-swapped polarity bit from the correct one. Writes with a zero sync width, and two writes in a row before one boundary, tell a design that filters and overwrites its pending set from one that does not.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
    localparam int H_BITS   = 10;
    localparam int V_BITS   = 10;
    localparam int S_BITS   = 6;
    localparam int POL_BITS = 5;
    localparam int HC_BITS  = H_BITS + 2;
    localparam int VC_BITS  = V_BITS + 2;

    // polarity select bit positions
    localparam int POL_HS  = 0;
    localparam int POL_VS  = 1;
    localparam int POL_DE  = 2;
    localparam int POL_DAT = 3;
    localparam int POL_CLK = 4;

    typedef struct packed {
        logic [S_BITS-1:0]  sync_m1;
        logic [H_BITS-1:0]  start;
        logic [H_BITS-1:0]  active;
        logic [HC_BITS-1:0] total_m1;
    } h_timing_t;

    typedef struct packed {
        logic [S_BITS-1:0]  sync_m1;
        logic [V_BITS-1:0]  start;
        logic [V_BITS-1:0]  active;
        logic [VC_BITS-1:0] total_m1;
    } v_timing_t;

    typedef struct packed {
        h_timing_t             h;
        v_timing_t             v;
        logic [POL_BITS-1:0]   pol;
    } timing_cfg_t;
endpackage

// File: rtl/lcd_cfg_latch.sv
module lcd_cfg_latch
    import lcd_sync_pkg::*;
#(
    parameter int DEF_H_SYNC   = 2,
    parameter int DEF_H_START  = 3,
    parameter int DEF_H_ACTIVE = 8,
    parameter int DEF_H_TAIL   = 2,
    parameter int DEF_V_SYNC   = 1,
    parameter int DEF_V_START  = 2,
    parameter int DEF_V_ACTIVE = 4,
    parameter int DEF_V_TAIL   = 1,
    parameter int DEF_POL      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                frame_end_i,
    input  logic [S_BITS-1:0]   h_sync_i,
    input  logic [H_BITS-1:0]   h_start_i,
    input  logic [H_BITS-1:0]   h_active_i,
    input  logic [H_BITS-1:0]   h_tail_i,
    input  logic [S_BITS-1:0]   v_sync_i,
    input  logic [V_BITS-1:0]   v_start_i,
    input  logic [V_BITS-1:0]   v_active_i,
    input  logic [V_BITS-1:0]   v_tail_i,
    input  logic [POL_BITS-1:0] pol_i,
    output timing_cfg_t         cfg_o
);
    function automatic timing_cfg_t pack_cfg(
        input logic [S_BITS-1:0]   hs,
        input logic [H_BITS-1:0]   hb,
        input logic [H_BITS-1:0]   ha,
        input logic [H_BITS-1:0]   ht,
        input logic [S_BITS-1:0]   vs,
        input logic [V_BITS-1:0]   vb,
        input logic [V_BITS-1:0]   va,
        input logic [V_BITS-1:0]   vt,
        input logic [POL_BITS-1:0] pl
    );
        timing_cfg_t c;
        c.h.sync_m1  = hs - S_BITS'(1);
        c.h.start    = hb;
        c.h.active   = ha;
        c.h.total_m1 = HC_BITS'(hb) + HC_BITS'(ha) + HC_BITS'(ht) - HC_BITS'(1);
        c.v.sync_m1  = vs - S_BITS'(1);
        c.v.start    = vb;
        c.v.active   = va;
        c.v.total_m1 = VC_BITS'(vb) + VC_BITS'(va) + VC_BITS'(vt) - VC_BITS'(1);
        c.pol        = pl;
        return c;
    endfunction

    localparam timing_cfg_t DEF_CFG = pack_cfg(
        S_BITS'(DEF_H_SYNC), H_BITS'(DEF_H_START), H_BITS'(DEF_H_ACTIVE), H_BITS'(DEF_H_TAIL),
        S_BITS'(DEF_V_SYNC), V_BITS'(DEF_V_START), V_BITS'(DEF_V_ACTIVE), V_BITS'(DEF_V_TAIL),
        POL_BITS'(DEF_POL));

    typedef struct packed {
        timing_cfg_t act;
        timing_cfg_t pend;
        logic        pend_vld;
    } latch_state_t;

    latch_state_t st_d, st_q;
    logic         legal;

    assign legal = (|h_sync_i) && (|v_sync_i);

    always_comb begin
        st_d = st_q;
        if (frame_end_i && st_q.pend_vld) begin
            st_d.act      = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (wr_i && legal) begin
            st_d.pend     = pack_cfg(h_sync_i, h_start_i, h_active_i, h_tail_i,
                                     v_sync_i, v_start_i, v_active_i, v_tail_i, pol_i);
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act      <= DEF_CFG;
            st_q.pend     <= DEF_CFG;
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.act;

    // R8: active timing only moves at a frame boundary
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(st_q.act));

    // R7: an illegal write leaves the pending set untouched
    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !legal && !frame_end_i) |=> ($stable(st_q.pend) && $stable(st_q.pend_vld)));
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
    parameter int FW = 10,
    parameter int CW = 12,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [SW-1:0] sync_m1_i,
    input  logic [FW-1:0] start_i,
    input  logic [FW-1:0] active_i,
    input  logic [CW-1:0] total_m1_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          in_sync_o,
    output logic          in_act_o,
    output logic [FW-1:0] pos_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] win_lo, win_hi;

    assign wrap_o = (cnt_q == total_m1_i);
    assign win_lo = CW'(start_i);
    assign win_hi = CW'(start_i) + CW'(active_i);

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) cnt_d = wrap_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o     = cnt_q;
    assign in_sync_o = (cnt_q <= CW'(sync_m1_i));
    assign in_act_o  = (cnt_q >= win_lo) && (cnt_q < win_hi);
    assign pos_o     = in_act_o ? FW'(cnt_q - win_lo) : '0;

    // R2/R3: count never runs past the programmed period
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= total_m1_i);
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int DEF_H_SYNC   = 2,
    parameter int DEF_H_START  = 3,
    parameter int DEF_H_ACTIVE = 8,
    parameter int DEF_H_TAIL   = 2,
    parameter int DEF_V_SYNC   = 1,
    parameter int DEF_V_START  = 2,
    parameter int DEF_V_ACTIVE = 4,
    parameter int DEF_V_TAIL   = 1,
    parameter int DEF_POL      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_en_i,
    input  logic                 cfg_wr_i,
    input  logic [S_BITS-1:0]    cfg_h_sync_i,
    input  logic [H_BITS-1:0]    cfg_h_start_i,
    input  logic [H_BITS-1:0]    cfg_h_active_i,
    input  logic [H_BITS-1:0]    cfg_h_tail_i,
    input  logic [S_BITS-1:0]    cfg_v_sync_i,
    input  logic [V_BITS-1:0]    cfg_v_start_i,
    input  logic [V_BITS-1:0]    cfg_v_active_i,
    input  logic [V_BITS-1:0]    cfg_v_tail_i,
    input  logic [POL_BITS-1:0]  cfg_pol_i,
    input  logic [DATA_BITS-1:0] pix_data_i,
    output logic                 hsync_o,
    output logic                 vsync_o,
    output logic                 de_o,
    output logic [DATA_BITS-1:0] pix_data_o,
    output logic                 pix_clk_o,
    output logic [H_BITS-1:0]    x_o,
    output logic [V_BITS-1:0]    y_o
);
    timing_cfg_t        cfg;
    logic               h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;
    logic               v_step, frame_end;
    logic [HC_BITS-1:0] h_cnt;
    logic [VC_BITS-1:0] v_cnt;

    assign v_step    = pix_en_i && h_wrap;
    assign frame_end = v_step && v_wrap;

    lcd_cfg_latch #(
        .DEF_H_SYNC(DEF_H_SYNC), .DEF_H_START(DEF_H_START),
        .DEF_H_ACTIVE(DEF_H_ACTIVE), .DEF_H_TAIL(DEF_H_TAIL),
        .DEF_V_SYNC(DEF_V_SYNC), .DEF_V_START(DEF_V_START),
        .DEF_V_ACTIVE(DEF_V_ACTIVE), .DEF_V_TAIL(DEF_V_TAIL),
        .DEF_POL(DEF_POL)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .frame_end_i(frame_end),
        .h_sync_i(cfg_h_sync_i), .h_start_i(cfg_h_start_i),
        .h_active_i(cfg_h_active_i), .h_tail_i(cfg_h_tail_i),
        .v_sync_i(cfg_v_sync_i), .v_start_i(cfg_v_start_i),
        .v_active_i(cfg_v_active_i), .v_tail_i(cfg_v_tail_i),
        .pol_i(cfg_pol_i), .cfg_o(cfg)
    );

    lcd_axis_cnt #(.FW(H_BITS), .CW(HC_BITS), .SW(S_BITS)) u_h (
        .clk(clk), .rst_n(rst_n), .step_i(pix_en_i),
        .sync_m1_i(cfg.h.sync_m1), .start_i(cfg.h.start), .active_i(cfg.h.active),
        .total_m1_i(cfg.h.total_m1), .cnt_o(h_cnt), .wrap_o(h_wrap),
        .in_sync_o(h_sync), .in_act_o(h_act), .pos_o(x_o)
    );

    lcd_axis_cnt #(.FW(V_BITS), .CW(VC_BITS), .SW(S_BITS)) u_v (
        .clk(clk), .rst_n(rst_n), .step_i(v_step),
        .sync_m1_i(cfg.v.sync_m1), .start_i(cfg.v.start), .active_i(cfg.v.active),
        .total_m1_i(cfg.v.total_m1), .cnt_o(v_cnt), .wrap_o(v_wrap),
        .in_sync_o(v_sync), .in_act_o(v_act), .pos_o(y_o)
    );

    // polarity: select bit 1 = active high / inverted
    assign hsync_o    = cfg.pol[POL_HS] ? h_sync : ~h_sync;
    assign vsync_o    = cfg.pol[POL_VS] ? v_sync : ~v_sync;
    assign de_o       = cfg.pol[POL_DE] ? (h_act && v_act) : ~(h_act && v_act);
    assign pix_data_o = pix_data_i ^ {DATA_BITS{cfg.pol[POL_DAT]}};
    assign pix_clk_o  = pix_en_i ^ cfg.pol[POL_CLK];

    // R5: no enable, no motion
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en_i |=> ($stable(h_cnt) && $stable(v_cnt)));

    // R3: rows step only at the end of a line
    p_vstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && !h_wrap) |=> $stable(v_cnt));
endmodule

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] din = 8'h00;
    int         cin [9];
    logic       hs, vs, de, pclk;
    logic [7:0] dout;
    logic [9:0] xo, yo;

    int act [9];
    int pnd [9];
    int pv, hc, vc;
    int n_cmp = 0, n_bad = 0;
    bit chk_on = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    lcd_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_en_i(pix_en), .cfg_wr_i(wr),
        .cfg_h_sync_i(6'(cin[0])), .cfg_h_start_i(10'(cin[1])),
        .cfg_h_active_i(10'(cin[2])), .cfg_h_tail_i(10'(cin[3])),
        .cfg_v_sync_i(6'(cin[4])), .cfg_v_start_i(10'(cin[5])),
        .cfg_v_active_i(10'(cin[6])), .cfg_v_tail_i(10'(cin[7])),
        .cfg_pol_i(5'(cin[8])), .pix_data_i(din),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_data_o(dout),
        .pix_clk_o(pclk), .x_o(xo), .y_o(yo)
    );

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            act = '{2, 3, 8, 2, 1, 2, 4, 1, 4};
            pnd = act;
            pv = 0; hc = 0; vc = 0;
        end else begin
            int ht, vt;
            bit bound;
            ht = act[1] + act[2] + act[3];
            vt = act[5] + act[6] + act[7];
            bound = pix_en && hc == ht - 1 && vc == vt - 1;
            if (pix_en) begin
                if (hc == ht - 1) begin
                    hc = 0;
                    vc = (vc == vt - 1) ? 0 : vc + 1;
                end else hc = hc + 1;
            end
            if (bound && pv != 0) begin act = pnd; pv = 0; end
            if (wr && cin[0] != 0 && cin[4] != 0) begin pnd = cin; pv = 1; end
        end
    end

    task automatic cmp(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual=%0d expected=%0d at %0t", req, phase, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_on) begin
        bit ah, av, sh, sv;
        int p;
        p  = act[8];
        sh = hc < act[0];
        sv = vc < act[4];
        ah = hc >= act[1] && hc < act[1] + act[2];
        av = vc >= act[5] && vc < act[5] + act[6];
        cmp("R2", "hsync", int'(hs), int'(p[0] ? sh : !sh));
        cmp("R3", "vsync", int'(vs), int'(p[1] ? sv : !sv));
        cmp("R4", "de", int'(de), int'(p[2] ? (ah && av) : !(ah && av)));
        cmp("R4", "x", int'(xo), ah ? hc - act[1] : 0);
        cmp("R4", "y", int'(yo), av ? vc - act[5] : 0);
        cmp("R6", "data", int'(dout), int'(din ^ {8{p[3]}}));
        cmp("R6", "pclk", int'(pclk), int'(pix_en ^ p[4]));
    end

    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            pix_en = (mode == 0) ? 1'b1 : (i % 3 != 0);
            din = 8'(i * 37 + 5);
            wr = 1'b0;
        end
    endtask

    task automatic write_cfg(int c [9]);
        @(posedge clk); #2;
        cin = c; wr = 1'b1;
        @(posedge clk); #2;
        wr = 1'b0;
    endtask

    initial begin
        cin = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk_on = 1'b1;
        phase = "R1";
        run(2, 0);
        phase = "R2";          // default timing, enable always high (R2 R3 R4)
        run(260, 0);
        phase = "R5";          // stalling enable
        run(300, 1);
        phase = "R7";          // zero sync widths are discarded
        write_cfg('{0, 4, 6, 3, 2, 1, 3, 2, 27});
        write_cfg('{3, 4, 6, 3, 0, 1, 3, 2, 27});
        run(300, 0);
        phase = "R8";          // mid-frame write, new polarity (R6)
        run(37, 0);
        write_cfg('{3, 4, 6, 3, 2, 1, 3, 2, 27});
        run(250, 1);
        phase = "R9";          // second write overrides first
        run(11, 0);
        write_cfg('{2, 2, 9, 1, 1, 2, 5, 1, 31});
        write_cfg('{1, 1, 5, 1, 1, 1, 2, 1, 5});
        run(200, 0);
        chk_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule